// File: doc/BRIEF.md
# DMA Window Address Translator

This block turns addresses arriving from an I/O bus into system memory addresses for DMA. It holds a small set of programmable windows. Each window has a base register, a mask register and a translated-base register, each 64 bits wide. A translation request presents a bus address. The windows are scanned from the lowest index upward, and the first enabled window whose unmasked upper address bits agree with the request supplies the result.

In a direct-mapped hit, the bits covered by the window mask pass through from the bus address, as do the low 20 bits. All remaining bits come from the translated base. Scatter-gather mode is not supported. A request that lands in an enabled scatter-gather window reports an error in place of an address.

Software programs the windows through a register port that accepts only 64-bit accesses. The register index is the byte offset shifted right by 6, so registers sit 64 bytes apart. Register slots that are reserved but not built report an error. So do slots that decode to nothing, and so does any access narrower than 64 bits.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset, all window registers read as zero, every response output is low or zero, and any translation misses.
- R2: A 64-bit register access addresses index `csr_addr >> 6`. The index map is: window base n at index n (0..3), window mask n at index 4+n, translated base n at index 8+n. A write is returned by a later read of the same index. `csr_ack`, `csr_rdata` and the error flags are registered and appear one cycle after `csr_req`.
- R3: An access with `csr_size` other than 3 (the size code is 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) sets `csr_size_err`, clears `csr_reg_err`, returns zero data and changes no register.
- R4: Index 12 is a control register that reads as zero and ignores writes. Index 13 is a table-invalidate register that reads as zero and accepts writes that have no effect. Neither sets an error flag.
- R5: Indices 14 through 21 are reserved and unimplemented, and indices 22 and above are undecoded. A 64-bit access to any of them sets `csr_reg_err`, returns zero data and changes no register.
- R6: A window matches when the bus address and its base register agree on every bit in the range 30..20 whose mask-register bit is 0. Bits outside 30..20 take no part in the match.
- R7: When several enabled windows match, the window with the lowest index supplies the result.
- R8: Bit 0 of a base register enables its window. A matching window with bit 0 clear is skipped, and the scan continues to later windows.
- R9: If the first enabled matching window has bit 1 of its base set (scatter-gather), the result has `xl_err` high, `xl_hit` low and a zero address. The scan does not go on to later windows.
- R10: On a direct-mapped hit, define the pass mask as (mask bits 30..20) OR 0xFFFFF. The output address is (translated base AND NOT pass) OR (bus address AND pass), and `xl_hit` is high.
- R11: When no enabled window matches, the output address is zero and both `xl_hit` and `xl_err` are low.
- R12: `xl_valid` rises exactly one cycle after `xl_req`. When `xl_valid` is low, the address, hit and error outputs are zero. A register write affects translations requested on any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk |
| csr_req | input | 1 | Register access strobe |
| csr_wr | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Byte offset within the block |
| csr_size | input | 2 | Access size code (3 = 64-bit) |
| csr_wdata | input | 64 | Write data |
| csr_ack | output | 1 | Access response, one cycle after the strobe |
| csr_rdata | output | 64 | Read data |
| csr_size_err | output | 1 | Access was not 64 bits wide |
| csr_reg_err | output | 1 | Index is reserved or undecoded |
| xl_req | input | 1 | Translation request strobe |
| xl_bus_addr | input | 64 | Bus address to translate |
| xl_valid | output | 1 | Translation result valid |
| xl_dma_addr | output | 64 | Translated system address |
| xl_hit | output | 1 | A direct-mapped window supplied the address |
| xl_err | output | 1 | Hit landed in an enabled scatter-gather window |

## Verification
The bound checker checks these properties on every cycle:
- the one-cycle response timing of both ports;
- that hit and error are never high together;
- that idle results are zero;
- that narrow accesses always produce a size error with zero data;
- that any hit keeps the low 20 address bits of the request.

Only bench scenarios can show the behaviours that depend on programmed register contents. These are window priority when windows overlap, fall-through past a disabled window, a scatter-gather window stopping the scan, the exact merged address, and the fact that rejected or ignored writes leave every register unchanged.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int unsigned REG_STRIDE_SHIFT = 6;
  localparam int unsigned NUM_UNIMPL       = 8;
endpackage

// File: rtl/dwx_csr.sv
module dwx_csr
  import dwx_pkg::*;
#(
  parameter int unsigned NWIN = 4,
  parameter int unsigned DW   = 64,
  parameter int unsigned AW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_req,
  input  logic          csr_wr,
  input  logic [AW-1:0] csr_addr,
  input  logic [1:0]    csr_size,
  input  logic [DW-1:0] csr_wdata,
  output logic          csr_ack,
  output logic [DW-1:0] csr_rdata,
  output logic          csr_size_err,
  output logic          csr_reg_err,
  output logic [DW-1:0] base_o  [NWIN],
  output logic [DW-1:0] mask_o  [NWIN],
  output logic [DW-1:0] xbase_o [NWIN]
);
  localparam int unsigned IDX_MASK0  = NWIN;
  localparam int unsigned IDX_XBASE0 = 2 * NWIN;
  localparam int unsigned IDX_CTRL   = 3 * NWIN;
  localparam int unsigned IDX_TLBALL = 3 * NWIN + 1;

  logic [DW-1:0] base_q [NWIN], base_n [NWIN];
  logic [DW-1:0] mask_q [NWIN], mask_n [NWIN];
  logic [DW-1:0] xbase_q[NWIN], xbase_n[NWIN];
  logic [AW-1:0] reg_idx;
  logic          size_ok, known, wr_en;
  logic [DW-1:0] rd_val;
  logic          ack_n, size_err_n, reg_err_n;
  logic [DW-1:0] rdata_n;

  assign reg_idx = csr_addr >> REG_STRIDE_SHIFT;
  assign size_ok = (csr_size == SZ_DWORD);
  assign wr_en   = csr_req && csr_wr && size_ok;

  always_comb begin
    rd_val = '0;
    known  = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      base_n[i]  = base_q[i];
      mask_n[i]  = mask_q[i];
      xbase_n[i] = xbase_q[i];
      if (reg_idx == AW'(i)) begin
        known  = 1'b1;
        rd_val = base_q[i];
        if (wr_en) base_n[i] = csr_wdata;
      end
      if (reg_idx == AW'(IDX_MASK0 + i)) begin
        known  = 1'b1;
        rd_val = mask_q[i];
        if (wr_en) mask_n[i] = csr_wdata;
      end
      if (reg_idx == AW'(IDX_XBASE0 + i)) begin
        known  = 1'b1;
        rd_val = xbase_q[i];
        if (wr_en) xbase_n[i] = csr_wdata;
      end
    end
    if (reg_idx == AW'(IDX_CTRL) || reg_idx == AW'(IDX_TLBALL)) known = 1'b1;
  end

  always_comb begin
    ack_n      = csr_req;
    size_err_n = csr_req && !size_ok;
    reg_err_n  = csr_req && size_ok && !known;
    rdata_n    = (csr_req && !csr_wr && size_ok && known) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i]  <= '0;
        mask_q[i]  <= '0;
        xbase_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i]  <= base_n[i];
        mask_q[i]  <= mask_n[i];
        xbase_q[i] <= xbase_n[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_ack      <= 1'b0;
      csr_size_err <= 1'b0;
      csr_reg_err  <= 1'b0;
      csr_rdata    <= '0;
    end else begin
      csr_ack      <= ack_n;
      csr_size_err <= size_err_n;
      csr_reg_err  <= reg_err_n;
      csr_rdata    <= rdata_n;
    end
  end

  always_comb begin
    for (int i = 0; i < NWIN; i++) begin
      base_o[i]  = base_q[i];
      mask_o[i]  = mask_q[i];
      xbase_o[i] = xbase_q[i];
    end
  end
endmodule

// File: rtl/dwx_window.sv
module dwx_window #(
  parameter int unsigned DW  = 64,
  parameter int unsigned MLO = 20,
  parameter int unsigned MHI = 30
) (
  input  logic [DW-1:0] bus_addr,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] xbase,
  output logic          match,
  output logic          enabled,
  output logic          sg_mode,
  output logic [DW-1:0] xlated
);
  localparam logic [DW-1:0] FIELD   = ((DW'(1) << (MHI - MLO + 1)) - DW'(1)) << MLO;
  localparam logic [DW-1:0] LOWPASS = (DW'(1) << MLO) - DW'(1);

  logic [DW-1:0] cmp_mask, pass_mask;

  always_comb begin
    cmp_mask  = ~mask & FIELD;
    pass_mask = (mask & FIELD) | LOWPASS;
    match     = (((bus_addr ^ base) & cmp_mask) == '0);
    enabled   = base[0];
    sg_mode   = base[1];
    xlated    = (xbase & ~pass_mask) | (bus_addr & pass_mask);
  end
endmodule

// File: rtl/dwx_select.sv
module dwx_select #(
  parameter int unsigned NWIN = 4,
  parameter int unsigned DW   = 64
) (
  input  logic [NWIN-1:0] match,
  input  logic [NWIN-1:0] enabled,
  input  logic [NWIN-1:0] sg_mode,
  input  logic [DW-1:0]   xlated [NWIN],
  output logic            hit,
  output logic            err,
  output logic [DW-1:0]   addr
);
  logic found;

  always_comb begin
    found = 1'b0;
    hit   = 1'b0;
    err   = 1'b0;
    addr  = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (!found && match[i] && enabled[i]) begin
        found = 1'b1;
        if (sg_mode[i]) begin
          err = 1'b1;
        end else begin
          hit  = 1'b1;
          addr = xlated[i];
        end
      end
    end
  end
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
  import dwx_pkg::*;
#(
  parameter int unsigned NWIN = 4,
  parameter int unsigned DW   = 64,
  parameter int unsigned AW   = 12,
  parameter int unsigned MLO  = 20,
  parameter int unsigned MHI  = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_req,
  input  logic          csr_wr,
  input  logic [AW-1:0] csr_addr,
  input  logic [1:0]    csr_size,
  input  logic [DW-1:0] csr_wdata,
  output logic          csr_ack,
  output logic [DW-1:0] csr_rdata,
  output logic          csr_size_err,
  output logic          csr_reg_err,
  input  logic          xl_req,
  input  logic [DW-1:0] xl_bus_addr,
  output logic          xl_valid,
  output logic [DW-1:0] xl_dma_addr,
  output logic          xl_hit,
  output logic          xl_err
);
  logic [DW-1:0]   base  [NWIN];
  logic [DW-1:0]   mask  [NWIN];
  logic [DW-1:0]   xbase [NWIN];
  logic [DW-1:0]   xlated[NWIN];
  logic [NWIN-1:0] w_match, w_en, w_sg;
  logic            sel_hit, sel_err;
  logic [DW-1:0]   sel_addr;
  logic            valid_n, hit_n, err_n;
  logic [DW-1:0]   addr_n;

  dwx_csr #(.NWIN(NWIN), .DW(DW), .AW(AW)) i_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_req(csr_req), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_size(csr_size), .csr_wdata(csr_wdata),
    .csr_ack(csr_ack), .csr_rdata(csr_rdata),
    .csr_size_err(csr_size_err), .csr_reg_err(csr_reg_err),
    .base_o(base), .mask_o(mask), .xbase_o(xbase)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    dwx_window #(.DW(DW), .MLO(MLO), .MHI(MHI)) i_win (
      .bus_addr(xl_bus_addr), .base(base[g]), .mask(mask[g]), .xbase(xbase[g]),
      .match(w_match[g]), .enabled(w_en[g]), .sg_mode(w_sg[g]), .xlated(xlated[g])
    );
  end

  dwx_select #(.NWIN(NWIN), .DW(DW)) i_sel (
    .match(w_match), .enabled(w_en), .sg_mode(w_sg), .xlated(xlated),
    .hit(sel_hit), .err(sel_err), .addr(sel_addr)
  );

  always_comb begin
    valid_n = xl_req;
    hit_n   = xl_req && sel_hit;
    err_n   = xl_req && sel_err;
    addr_n  = xl_req ? sel_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid    <= 1'b0;
      xl_hit      <= 1'b0;
      xl_err      <= 1'b0;
      xl_dma_addr <= '0;
    end else begin
      xl_valid    <= valid_n;
      xl_hit      <= hit_n;
      xl_err      <= err_n;
      xl_dma_addr <= addr_n;
    end
  end
endmodule

// File: rtl/dwx_checker.sv
module dwx_checker #(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csr_req,
  input logic          csr_wr,
  input logic [AW-1:0] csr_addr,
  input logic [1:0]    csr_size,
  input logic [DW-1:0] csr_wdata,
  input logic          csr_ack,
  input logic [DW-1:0] csr_rdata,
  input logic          csr_size_err,
  input logic          csr_reg_err,
  input logic          xl_req,
  input logic [DW-1:0] xl_bus_addr,
  input logic          xl_valid,
  input logic [DW-1:0] xl_dma_addr,
  input logic          xl_hit,
  input logic          xl_err
);
  // R12
  xl_valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_valid);
  // R12
  xl_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> (!xl_valid && !xl_hit && !xl_err && xl_dma_addr == '0));
  // R9
  hit_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_hit && xl_err));
  // R10
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> (xl_hit -> xl_dma_addr[19:0] == $past(xl_bus_addr[19:0])));
  // R3
  narrow_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_size != 2'd3) |=> (csr_size_err && !csr_reg_err && csr_rdata == '0));
  // R2
  csr_ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req |=> csr_ack);
  // R2
  csr_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_req |=> (!csr_ack && !csr_size_err && !csr_reg_err));
endmodule

bind dma_window_xlate dwx_checker #(.DW(DW), .AW(AW)) i_dwx_checker (.*);

// File: tb/test_dma_window_xlate.sv
module test_dma_window_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_req = 1'b0, csr_wr = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_size = 2'd3;
  logic [63:0] csr_wdata = '0;
  logic        csr_ack, csr_size_err, csr_reg_err;
  logic [63:0] csr_rdata;
  logic        xl_req = 1'b0;
  logic [63:0] xl_bus_addr = '0;
  logic        xl_valid, xl_hit, xl_err;
  logic [63:0] xl_dma_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_window_xlate i_dma_window_xlate (.*);

  // Translation vectors after programming: address in, expected address, hit
  localparam int NV = 6;
  localparam logic [63:0] V_IN  [NV] = '{64'h0000_0000_4123_4567, 64'h0000_0000_4001_2345,
                                         64'h0000_0000_080A_BCDE, 64'h0000_0000_0012_3456,
                                         64'h0000_0000_3000_0000, 64'hFFFF_FFFF_4123_4567};
  localparam logic [63:0] V_EXP [NV] = '{64'h0000_0001_0123_4567, 64'h0000_0001_0001_2345,
                                         64'h0000_0005_080A_BCDE, 64'h0000_0005_0012_3456,
                                         64'h0,                   64'h0000_0001_0123_4567};
  localparam logic [NV-1:0] V_HIT = 6'b101111;  // bit k = vector k
  localparam string V_REQ [NV] = '{"R10", "R7", "R8", "R6", "R11", "R6"};

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr(bit wr, int idx, logic [1:0] sz, logic [63:0] d);
    @(negedge clk);
    csr_req = 1'b1; csr_wr = wr; csr_addr = 12'(idx << 6); csr_size = sz; csr_wdata = d;
    @(negedge clk);
    csr_req = 1'b0; csr_wr = 1'b0;
  endtask

  task automatic xlate(logic [63:0] a);
    @(negedge clk);
    xl_req = 1'b1; xl_bus_addr = a;
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", {62'd0, xl_valid, csr_ack}, 64'd0);
    csr(1'b0, 0, 2'd3, '0);
    check("R1", csr_rdata, 64'd0);
    xlate(64'h4000_0000);
    check("R1", {61'd0, xl_valid, xl_hit, xl_err}, 64'd4);

    // Program windows
    csr(1'b1, 0, 2'd3, 64'h4000_0001); csr(1'b1, 4, 2'd3, 64'h3FF0_0000); csr(1'b1, 8,  2'd3, 64'h1_0000_0000);
    csr(1'b1, 1, 2'd3, 64'h4000_0001); csr(1'b1, 5, 2'd3, 64'h0);         csr(1'b1, 9,  2'd3, 64'h2_0000_0000);
    csr(1'b1, 2, 2'd3, 64'h0800_0000); csr(1'b1, 6, 2'd3, 64'h0);         csr(1'b1, 10, 2'd3, 64'h3_0000_0000);
    csr(1'b1, 3, 2'd3, 64'h0800_0001); csr(1'b1, 7, 2'd3, 64'h0FF0_0000); csr(1'b1, 11, 2'd3, 64'h5_0000_0000);
    // R2: readback
    csr(1'b0, 7, 2'd3, '0);
    check("R2", csr_rdata, 64'h0FF0_0000);
    csr(1'b0, 9, 2'd3, '0);
    check("R2", csr_rdata, 64'h2_0000_0000);

    for (int k = 0; k < NV; k++) begin
      xlate(V_IN[k]);
      check(V_REQ[k], xl_dma_addr, V_EXP[k]);
      check(V_REQ[k], {63'd0, xl_hit}, {63'd0, V_HIT[k]});
    end

    // R3: byte write rejected, state kept
    csr(1'b1, 0, 2'd0, 64'h0);
    check("R3", {62'd0, csr_size_err, csr_reg_err}, 64'd2);
    csr(1'b0, 0, 2'd2, '0);
    check("R3", {62'd0, csr_size_err, csr_reg_err}, 64'd2);
    csr(1'b0, 0, 2'd3, '0);
    check("R3", csr_rdata, 64'h4000_0001);

    // R4: control and invalidate registers
    csr(1'b1, 12, 2'd3, 64'hFFFF);
    check("R4", {62'd0, csr_size_err, csr_reg_err}, 64'd0);
    csr(1'b0, 12, 2'd3, '0);
    check("R4", csr_rdata, 64'd0);
    csr(1'b1, 13, 2'd3, 64'h1234);
    csr(1'b0, 13, 2'd3, '0);
    check("R4", {csr_rdata[62:0], csr_reg_err}, 64'd0);

    // R5: reserved and undecoded indices
    csr(1'b0, 15, 2'd3, '0);
    check("R5", {62'd0, csr_reg_err, csr_size_err}, 64'd2);
    csr(1'b1, 40, 2'd3, 64'hDEAD);
    check("R5", {62'd0, csr_reg_err, csr_size_err}, 64'd2);
    xlate(64'h4123_4567);
    check("R5", xl_dma_addr, 64'h1_0123_4567);

    // R9: scatter-gather window stops the scan
    csr(1'b1, 0, 2'd3, 64'h4000_0003);
    xlate(64'h4123_4567);
    check("R9", {xl_dma_addr[61:0], xl_hit, xl_err}, 64'd1);
    xlate(64'h4001_2345);
    check("R9", {xl_dma_addr[61:0], xl_hit, xl_err}, 64'd1);

    // R8: disabled window 0 falls through to window 1
    csr(1'b1, 0, 2'd3, 64'h4000_0000);
    xlate(64'h4001_2345);
    check("R8", xl_dma_addr, 64'h2_0001_2345);
    xlate(64'h4123_4567);
    check("R11", {xl_dma_addr[61:0], xl_hit, xl_err}, 64'd0);

    // R12: idle cycle after request
    @(negedge clk);
    check("R12", {63'd0, xl_valid}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule